// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory below it. Word stores enter on a valid/ready port and are held as block-sized entries. Each entry covers one aligned block of four words and carries one valid bit per word. A store whose block already has a pending entry is folded into that entry. Sequential stores to one block therefore leave one memory write with several word enables set, instead of one write per word.

Entries leave toward memory in the order they were allocated. The oldest entry is offered on the drain port, with its block address, all four data lanes and the four word enables, whenever the buffer holds anything. It is removed on the valid/ready handshake.

A lookup port compares a block address with every pending entry. The miss path of the cache uses it to hold a read back until any older write to the same block has reached memory.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `drain_valid_o` is 0, `st_ready_o` is 1 and `lookup_hit_o` is 0.
- R2: The store address is a byte address. Bits [1:0] are ignored, bits [3:2] select the word and the upper bits form the block address. A store to a block with no pending entry allocates a new entry that holds only that word. The entry offers a word enable of `1 << word` and carries the data in lane `drain_data_o[32*word +: 32]`.
- R3: A store to a block that has a mergeable pending entry sets that entry's enable bit and writes its lane. Four stores to words 0..3 of one block give a single drain with enables 4'b1111.
- R4: A store to a word whose enable bit is already set replaces that lane's data. The drain carries the most recent value.
- R5: Entries are drained in allocation order. An entry is removed on the cycle that `drain_valid_o` and `drain_ready_i` are both high.
- R6: While `drain_ready_i` is low and no store is accepted, the drain outputs stay unchanged in the next cycle.
- R7: A store to the head entry's block in the cycle that the head is handed to memory does not merge into it. It allocates a new entry whose enables hold only the new word.
- R8: `st_ready_o` is low exactly when all 4 entries are pending and no mergeable entry matches the store. A store that can merge is accepted even when the buffer is full.
- R9: `lookup_hit_o` is 1 exactly when some pending entry, the head included, has block address `lookup_blk_i`. It is combinational in the same cycle.
- R10: Stores to different blocks never share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_addr_i | input | 32 | Store byte address |
| st_data_i | input | 32 | Store data word |
| drain_valid_o | output | 1 | Oldest entry offered to memory |
| drain_ready_i | input | 1 | Memory takes the offered entry |
| drain_blk_o | output | 28 | Block address of offered entry |
| drain_data_o | output | 128 | Four data lanes, word w at bits 32w+31:32w |
| drain_wen_o | output | 4 | Per-word write enables |
| lookup_blk_i | input | 28 | Block address to look up |
| lookup_hit_o | output | 1 | A pending entry holds this block |

## Verification
On every cycle, the assertions check the following:
- ready is never withheld while a slot is free;
- at most one entry can take a merge;
- the entry being handed off is never a merge target;
- the offered entry holds still while memory stalls;
- an empty buffer never reports a lookup hit.

The data contents can only be shown by the bench scenarios. These cover the merged enables after sequential stores, the overwrite of a lane, strict allocation order, the new entry made when a store races the head's handshake, and the stall when all four entries are full. The bench checks them against a queue model cycle by cycle, under directed sequences and random traffic over a small pool of blocks.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } st_act_e;
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
  parameter int unsigned N     = 4,
  parameter int unsigned KEY_W = 28
) (
  input  logic [N-1:0]       valid_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [N*KEY_W-1:0] keys_i,
  output logic [N-1:0]       hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (keys_i[i*KEY_W +: KEY_W] == key_i);
  end
endmodule

// File: rtl/wbuf_ring.sv
module wbuf_ring #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned LANE_W = $clog2(DATA_W / 8),
  localparam int unsigned WOFS_W = $clog2(WORDS),
  localparam int unsigned BLK_W  = ADDR_W - LANE_W - WOFS_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  output logic                    drain_valid_o,
  input  logic                    drain_ready_i,
  output logic [BLK_W-1:0]        drain_blk_o,
  output logic [WORDS*DATA_W-1:0] drain_data_o,
  output logic [WORDS-1:0]        drain_wen_o,
  input  logic [BLK_W-1:0]        lookup_blk_i,
  output logic                    lookup_hit_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]        vld_q;
  logic [BLK_W-1:0]        blk_q [DEPTH];
  logic [WORDS-1:0]        wen_q [DEPTH];
  logic [WORDS*DATA_W-1:0] dat_q [DEPTH];
  logic [DEPTH*BLK_W-1:0]  blk_flat;

  logic [PTR_W-1:0]  head, tail;
  logic              empty, full;
  logic [BLK_W-1:0]  st_blk;
  logic [WOFS_W-1:0] st_word;
  logic [DEPTH-1:0]  merge_ok, st_hit, lk_hit;
  logic              drain_fire, merge_hit, st_fire;
  st_act_e           st_act;
  logic              unused_lane;

  assign st_blk      = st_addr_i[ADDR_W-1 -: BLK_W];
  assign st_word     = st_addr_i[LANE_W +: WOFS_W];
  assign unused_lane = ^st_addr_i[LANE_W-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign blk_flat[i*BLK_W +: BLK_W] = blk_q[i];
  end

  assign drain_fire = !empty && drain_ready_i;

  // head is handed off this cycle: keep it out of merging
  always_comb begin
    merge_ok = vld_q;
    if (drain_fire) merge_ok[head] = 1'b0;
  end

  wbuf_cam #(.N(DEPTH), .KEY_W(BLK_W)) u_st_cam (
    .valid_i(merge_ok), .key_i(st_blk), .keys_i(blk_flat), .hit_o(st_hit)
  );
  wbuf_cam #(.N(DEPTH), .KEY_W(BLK_W)) u_lk_cam (
    .valid_i(vld_q), .key_i(lookup_blk_i), .keys_i(blk_flat), .hit_o(lk_hit)
  );

  assign merge_hit  = |st_hit;
  assign st_ready_o = merge_hit || !full;
  assign st_fire    = st_valid_i && st_ready_o;

  always_comb begin
    st_act = ACT_NONE;
    if (st_fire) st_act = merge_hit ? ACT_MERGE : ACT_ALLOC;
  end

  wbuf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .push_i (st_act == ACT_ALLOC),
    .pop_i  (drain_fire),
    .head_o (head),
    .tail_o (tail),
    .empty_o(empty),
    .full_o (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic do_alloc, do_merge;
    assign do_alloc = (st_act == ACT_ALLOC) && (tail == PTR_W'(i));
    assign do_merge = (st_act == ACT_MERGE) && st_hit[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        blk_q[i] <= '0;
        wen_q[i] <= '0;
        dat_q[i] <= '0;
      end else begin
        if (drain_fire && head == PTR_W'(i)) vld_q[i] <= 1'b0;
        if (do_alloc) begin
          vld_q[i] <= 1'b1;
          blk_q[i] <= st_blk;
          wen_q[i] <= WORDS'(1) << st_word;
        end else if (do_merge) begin
          wen_q[i][st_word] <= 1'b1;
        end
        for (int w = 0; w < WORDS; w++) begin
          if ((do_alloc || do_merge) && st_word == WOFS_W'(w))
            dat_q[i][w*DATA_W +: DATA_W] <= st_data_i;
        end
      end
    end
  end

  assign drain_valid_o = !empty;
  assign drain_blk_o   = blk_q[head];
  assign drain_wen_o   = wen_q[head];
  assign drain_data_o  = dat_q[head];
  assign lookup_hit_o  = |lk_hit;

  assert_ready_not_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full |-> st_ready_o);
  assert_merge_unique_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(st_hit));
  assert_no_head_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_fire |-> !st_hit[head]);
  assert_head_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty |-> vld_q[head]);
  assert_drain_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_valid_o && !drain_ready_i && !st_fire) |=>
      (drain_valid_o && $stable(drain_blk_o) && $stable(drain_wen_o) && $stable(drain_data_o)));
  assert_lookup_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !lookup_hit_o);
endmodule

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic         drain_valid;
  logic         drain_ready = 1'b0;
  logic [27:0]  drain_blk;
  logic [127:0] drain_data;
  logic [3:0]   drain_wen;
  logic [27:0]  lookup_blk = '0;
  logic         lookup_hit;

  int checks = 0;
  int errors = 0;

  // queue model, index 0 = oldest
  int          m_cnt = 0;
  logic [27:0] m_blk [4];
  logic [3:0]  m_wen [4];
  logic [31:0] m_dat [4][4];

  always #2 clk = ~clk;

  merge_wbuf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready),
    .st_addr_i(st_addr), .st_data_i(st_data),
    .drain_valid_o(drain_valid), .drain_ready_i(drain_ready),
    .drain_blk_o(drain_blk), .drain_data_o(drain_data), .drain_wen_o(drain_wen),
    .lookup_blk_i(lookup_blk), .lookup_hit_o(lookup_hit)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [27:0] b, input int w);
    return {b, 2'(w), 2'b00};
  endfunction

  function automatic bit model_hit(input logic [27:0] b);
    for (int i = 0; i < m_cnt; i++) if (m_blk[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                      input bit dr, input logic [27:0] lk);
    int idx;
    bit fire, exp_rdy;
    logic [27:0] b;
    int w;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d; drain_ready = dr; lookup_blk = lk;
    #1;
    b = a[31:4]; w = int'(a[3:2]);
    fire = (m_cnt > 0) && dr;
    idx = -1;
    for (int i = 0; i < m_cnt; i++)
      if (idx < 0 && m_blk[i] == b && !(i == 0 && fire)) idx = i;
    exp_rdy = (idx >= 0) || (m_cnt < 4);
    chk(st_ready == exp_rdy, "R8 ready", 64'(st_ready), 64'(exp_rdy));
    chk(drain_valid == (m_cnt > 0), "R5 drain_valid", 64'(drain_valid), 64'(m_cnt > 0));
    chk(lookup_hit == model_hit(lk), "R9 lookup", 64'(lookup_hit), 64'(model_hit(lk)));
    if (m_cnt > 0) begin
      chk(drain_blk == m_blk[0], "R5 drain_blk", 64'(drain_blk), 64'(m_blk[0]));
      chk(drain_wen == m_wen[0], "R3 drain_wen", 64'(drain_wen), 64'(m_wen[0]));
      for (int k = 0; k < 4; k++)
        if (m_wen[0][k])
          chk(drain_data[32*k +: 32] == m_dat[0][k], "R4 drain lane",
              64'(drain_data[32*k +: 32]), 64'(m_dat[0][k]));
    end
    if (v && exp_rdy) begin
      if (idx >= 0) begin
        m_wen[idx][w] = 1'b1;
        m_dat[idx][w] = d;
      end else begin
        m_blk[m_cnt] = b;
        m_wen[m_cnt] = 4'(1 << w);
        m_dat[m_cnt][w] = d;
        m_cnt++;
      end
    end
    if (fire) begin
      for (int i = 0; i < 3; i++) begin
        m_blk[i] = m_blk[i+1];
        m_wen[i] = m_wen[i+1];
        m_dat[i] = m_dat[i+1];
      end
      m_cnt--;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0; drain_ready = 1'b0;
  endtask

  task automatic drain_all();
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b1, 28'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(drain_valid == 1'b0, "R1 drain_valid", 64'(drain_valid), 64'd0);
    chk(st_ready == 1'b1, "R1 st_ready", 64'(st_ready), 64'd1);
    chk(lookup_hit == 1'b0, "R1 lookup_hit", 64'(lookup_hit), 64'd0);

    // R2 single store, low byte bits ignored
    step(1'b1, mk_addr(28'd9, 2) | 32'h3, 32'hA0A0_0002, 1'b0, 28'd9);
    chk(drain_blk == 28'd9 && drain_wen == 4'b0100, "R2 alloc", {drain_blk, drain_wen}, {28'd9, 4'b0100});
    chk(drain_data[64 +: 32] == 32'hA0A0_0002, "R2 lane", 64'(drain_data[64 +: 32]), 64'hA0A0_0002);
    drain_all();

    // R3 sequential words of one block merge
    for (int w = 0; w < 4; w++) step(1'b1, mk_addr(28'd6, w), 32'h6000 + w, 1'b0, 28'd6);
    chk(drain_wen == 4'b1111 && drain_blk == 28'd6 && m_cnt == 1, "R3 merged",
        {drain_blk, drain_wen}, {28'd6, 4'b1111});

    // R4 overwrite
    step(1'b1, mk_addr(28'd6, 1), 32'hDEAD_BEEF, 1'b0, 28'd6);
    chk(drain_data[32 +: 32] == 32'hDEAD_BEEF, "R4 overwrite", 64'(drain_data[32 +: 32]), 64'hDEAD_BEEF);

    // R10 other block takes its own entry
    step(1'b1, mk_addr(28'd7, 0), 32'h7000, 1'b0, 28'd7);
    chk(drain_wen == 4'b1111 && m_cnt == 2, "R10 separate", 64'(drain_wen), 64'hf);

    // R5 ordered drain
    step(1'b0, '0, '0, 1'b1, 28'd6);
    chk(drain_blk == 28'd7 && drain_wen == 4'b0001, "R5 order", {drain_blk, drain_wen}, {28'd7, 4'b0001});

    // R7 store to head block during its handshake
    step(1'b1, mk_addr(28'd7, 2), 32'h7002, 1'b1, 28'd7);
    chk(drain_blk == 28'd7 && drain_wen == 4'b0100, "R7 new entry", {drain_blk, drain_wen}, {28'd7, 4'b0100});
    drain_all();

    // R8 full buffer
    for (int b = 1; b <= 4; b++) step(1'b1, mk_addr(28'(b), 0), 32'h100 * b, 1'b0, 28'd0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = mk_addr(28'd5, 0); #1;
    chk(st_ready == 1'b0, "R8 full stall", 64'(st_ready), 64'd0);
    st_addr = mk_addr(28'd2, 3); #1;
    chk(st_ready == 1'b1, "R8 merge when full", 64'(st_ready), 64'd1);
    st_valid = 1'b0;
    step(1'b1, mk_addr(28'd5, 0), 32'h500, 1'b0, 28'd5);
    step(1'b1, mk_addr(28'd2, 3), 32'h203, 1'b0, 28'd2);
    drain_all();

    // R6 stall holds output (checked by model each step)
    step(1'b1, mk_addr(28'd3, 1), 32'h31, 1'b0, 28'd3);
    step(1'b0, '0, '0, 1'b0, 28'd3);
    chk(drain_blk == 28'd3 && drain_wen == 4'b0010, "R6 hold", {drain_blk, drain_wen}, {28'd3, 4'b0010});

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [27:0] rb;
      rb = 28'($urandom_range(0, 5));
      step($urandom_range(0, 3) != 0, mk_addr(rb, int'($urandom_range(0, 3))), $urandom(),
           $urandom_range(0, 1) == 1, 28'($urandom_range(0, 5)));
    end
    drain_all();
    chk(drain_valid == 1'b0, "R5 empty at end", 64'(drain_valid), 64'd0);
    finish_run();
  end
endmodule